// File: doc/BRIEF.md
# Bitstream Security Policy Controller

This block sits at the front of a configuration loader and rules on each incoming bitstream before any of it reaches the configuration memory. It keeps track of which keys the device holds (a battery-backed key that may be rewritten or erased, and a fuse key that can be set only once) and whether each of them was stored with tamper protection. From that it derives a security mode. When the loader announces a new stream, the controller looks at the mode, the port the stream arrives on (the JTAG port or the serial/parallel configuration port) and whether the stream header says the data is encrypted. It then accepts the stream, refuses it, or asks the decryptor to verify the key first.

For accepted streams it drives the datapath select: the decryptor is bypassed for plain data, and when a stream is both encrypted and compressed the data is decrypted first and decompressed second. A refusal drops the active-low status line for a fixed number of cycles. A failed key check does the same and then, after a recovery gap, waits for a new key verdict, so a stream that keeps failing produces a steady train of low pulses rather than a single error. A saturating count of key-check failures is kept for inspection.

Top module: `bitsec_policy_ctrl`

## Requirements
- R1: `mode_code` gives the security mode: 0 no key, 1 battery key, 2 battery key with tamper protection, 3 fuse key, 4 fuse key with tamper protection. The fuse key takes priority over the battery key, and the tamper bit shown is that of the key in use. The code changes on the clock edge that takes a program or erase strobe.
- R2: With no key stored, a plain stream on either port is accepted: `cfg_accept` pulses for one cycle on the edge after the start strobe, `dec_bypass` is 1 and `route` is `{cfg_cmp, 0}`.
- R3: With a key stored and no tamper protection, a plain stream is accepted with the decryptor bypassed, and an encrypted stream on the configuration port enters the key check (`dec_bypass` 0, no accept or reject) and is accepted on the edge that takes a passing verdict (`key_vld` and `key_ok` both 1).
- R4: In modes 2 and 4 a plain stream is refused: `cfg_reject` pulses on the edge after the start strobe.
- R5: A stream on the JTAG port (`cfg_jtag` 1) is refused if it is encrypted, and refused whatever its header says when the mode has tamper protection.
- R6: With no key stored (mode 0), an encrypted stream is refused.
- R7: A failing verdict (`key_vld` 1, `key_ok` 0) during the key check pulses `cfg_reject`, holds `status_n` low for PULSE_W cycles, then high for RETRY_GAP cycles, after which a new verdict is taken; `fail_count` increases by one per failing verdict and stops at its all-ones value.
- R8: A refusal taken at the start strobe holds `status_n` low for exactly PULSE_W cycles and then returns to idle without retrying, leaves `dec_bypass` at 1 and `fail_count` unchanged; `cfg_accept` and `cfg_reject` are never high together.
- R9: Once the fuse key is set, further fuse program strobes are ignored, including their tamper bit.
- R10: The battery key can be reprogrammed (with a new tamper bit) or erased at any time; an erase in the same cycle as a program wins.
- R11: `route` bit 0 enables the decrypt stage and bit 1 the decompress stage; code 3 means decrypt first, then decompress. An accepted encrypted, compressed stream shows code 3.
- R12: Start strobes arriving while a key check, a low pulse or a recovery gap is in progress are ignored.
- R13: After reset `status_n` is 1, `mode_code` 0, `dec_bypass` 1, `route` 0, `fail_count` 0, and neither result pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| vol_prog | input | 1 | Program strobe for the battery-backed key |
| vol_erase | input | 1 | Erase strobe for the battery-backed key |
| vol_tamper_in | input | 1 | Tamper bit stored with a battery key program |
| nv_prog | input | 1 | Program strobe for the one-time fuse key |
| nv_tamper_in | input | 1 | Tamper bit stored with the fuse key |
| cfg_start | input | 1 | A new configuration stream begins |
| cfg_jtag | input | 1 | 1: stream arrives on JTAG, 0: configuration port |
| cfg_enc | input | 1 | Stream header marks the data as encrypted |
| cfg_cmp | input | 1 | Stream data is compressed |
| key_vld | input | 1 | Decryptor key-check verdict is valid |
| key_ok | input | 1 | Key-check verdict: 1 pass, 0 fail |
| dec_bypass | output | 1 | 1: data routed around the decryptor |
| route | output | 2 | Datapath stage enables (bit 0 decrypt, bit 1 decompress) |
| cfg_accept | output | 1 | One-cycle pulse: stream accepted |
| cfg_reject | output | 1 | One-cycle pulse: stream refused or key check failed |
| status_n | output | 1 | Active-low status, low during a failure pulse |
| mode_code | output | 3 | Current security mode |
| fail_count | output | FAIL_W | Saturating count of failed key checks |

## Verification
A wrong key-store state shows at `mode_code` one cycle after the strobe that caused it, and again in the accept or reject pulse of the next stream, which comes out one cycle after its start strobe. A wrong sequencer state shows as a `status_n` low pulse that is too long, too short or missing, as a verdict taken during the recovery gap, or as a start strobe that is acted on while busy; each of these shows within PULSE_W plus RETRY_GAP cycles of the failing verdict. A bad failure tally shows on `fail_count` one cycle after each failing verdict, and a saturation fault after the counter reaches its all-ones value.

// File: rtl/sec_pol_pkg.sv
package sec_pol_pkg;

  typedef enum logic [2:0] {
    SM_NONE    = 3'd0,
    SM_VOL     = 3'd1,
    SM_VOL_TMP = 3'd2,
    SM_NV      = 3'd3,
    SM_NV_TMP  = 3'd4
  } sec_mode_e;

  typedef enum logic [1:0] {
    DC_REJECT = 2'd0,
    DC_PLAIN  = 2'd1,
    DC_KEYCHK = 2'd2
  } decision_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_KEYCHK = 3'd1,
    ST_DONE   = 3'd2,
    ST_PULSE  = 3'd3,
    ST_GAP    = 3'd4
  } seq_state_e;

  // Mode from key-store state; fuse key wins over battery key.
  function automatic sec_mode_e select_mode(logic v_has, logic v_tmp,
                                            logic n_has, logic n_tmp);
    sec_mode_e m;
    if (n_has)      m = n_tmp ? SM_NV_TMP : SM_NV;
    else if (v_has) m = v_tmp ? SM_VOL_TMP : SM_VOL;
    else            m = SM_NONE;
    return m;
  endfunction

  function automatic logic mode_tamper(sec_mode_e m);
    return (m == SM_VOL_TMP) || (m == SM_NV_TMP);
  endfunction

  function automatic logic mode_keyed(sec_mode_e m);
    return m != SM_NONE;
  endfunction

  // Policy for a new stream.
  function automatic decision_e decide(sec_mode_e m, logic jtag, logic enc);
    decision_e d;
    if (jtag) begin
      // No decryption on the JTAG path; refused outright under tamper protection.
      if (enc || mode_tamper(m)) d = DC_REJECT;
      else                       d = DC_PLAIN;
    end else if (!enc) begin
      d = mode_tamper(m) ? DC_REJECT : DC_PLAIN;
    end else begin
      d = mode_keyed(m) ? DC_KEYCHK : DC_REJECT;
    end
    return d;
  endfunction

  // Stage enables: bit 0 decrypt, bit 1 decompress; both means decrypt first.
  function automatic logic [1:0] route_for(logic enc, logic cmp);
    return {cmp, enc};
  endfunction

endpackage

// File: rtl/sec_key_store.sv
module sec_key_store
  import sec_pol_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vol_prog,
  input  logic      vol_erase,
  input  logic      vol_tamper_in,
  input  logic      nv_prog,
  input  logic      nv_tamper_in,
  output sec_mode_e mode,
  output logic      nv_locked
);

  logic v_has, v_tmp;
  logic n_has, n_tmp;

  // Battery-backed key: rewritable, erase wins over program.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_has <= 1'b0;
      v_tmp <= 1'b0;
    end else if (vol_erase) begin
      v_has <= 1'b0;
      v_tmp <= 1'b0;
    end else if (vol_prog) begin
      v_has <= 1'b1;
      v_tmp <= vol_tamper_in;
    end
  end

  // Fuse key: set once, later requests have no effect.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_has <= 1'b0;
      n_tmp <= 1'b0;
    end else if (nv_prog && !n_has) begin
      n_has <= 1'b1;
      n_tmp <= nv_tamper_in;
    end
  end

  assign mode      = select_mode(v_has, v_tmp, n_has, n_tmp);
  assign nv_locked = n_has;

endmodule

// File: rtl/sec_fail_tally.sv
module sec_fail_tally #(
  parameter int FAIL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_fail,
  output logic [FAIL_W-1:0] count
);

  localparam logic [FAIL_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          count <= '0;
    else if (key_fail && count != CNT_MAX) count <= count + 1'b1;
  end

endmodule

// File: rtl/sec_cfg_seq.sv
module sec_cfg_seq
  import sec_pol_pkg::*;
#(
  parameter int PULSE_W   = 4,
  parameter int RETRY_GAP = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sec_mode_e  mode,
  input  logic       cfg_start,
  input  logic       cfg_jtag,
  input  logic       cfg_enc,
  input  logic       cfg_cmp,
  input  logic       key_vld,
  input  logic       key_ok,
  output logic       cfg_accept,
  output logic       cfg_reject,
  output logic       status_n,
  output logic       dec_bypass,
  output logic [1:0] route,
  output logic       start_taken,
  output logic       key_fail
);

  localparam int SPAN  = (PULSE_W > RETRY_GAP) ? PULSE_W : RETRY_GAP;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_W - 1);
  localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(RETRY_GAP - 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             retry;
  logic             enc_active;
  decision_e        dec_now;

  assign start_taken = cfg_start && ((state == ST_IDLE) || (state == ST_DONE));
  assign key_fail    = (state == ST_KEYCHK) && key_vld && !key_ok;
  assign dec_now     = decide(mode, cfg_jtag, cfg_enc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      retry      <= 1'b0;
      enc_active <= 1'b0;
      route      <= 2'b00;
      cfg_accept <= 1'b0;
      cfg_reject <= 1'b0;
    end else begin
      cfg_accept <= 1'b0;
      cfg_reject <= 1'b0;
      case (state)
        ST_IDLE, ST_DONE: begin
          if (start_taken) begin
            case (dec_now)
              DC_PLAIN: begin
                cfg_accept <= 1'b1;
                enc_active <= 1'b0;
                route      <= route_for(1'b0, cfg_cmp);
                state      <= ST_DONE;
              end
              DC_KEYCHK: begin
                enc_active <= 1'b1;
                route      <= route_for(1'b1, cfg_cmp);
                state      <= ST_KEYCHK;
              end
              default: begin
                cfg_reject <= 1'b1;
                enc_active <= 1'b0;
                route      <= 2'b00;
                retry      <= 1'b0;
                cnt        <= PULSE_LD;
                state      <= ST_PULSE;
              end
            endcase
          end
        end
        ST_KEYCHK: begin
          if (key_vld) begin
            if (key_ok) begin
              cfg_accept <= 1'b1;
              state      <= ST_DONE;
            end else begin
              cfg_reject <= 1'b1;
              retry      <= 1'b1;
              cnt        <= PULSE_LD;
              state      <= ST_PULSE;
            end
          end
        end
        ST_PULSE: begin
          if (cnt == '0) begin
            if (retry) begin
              cnt   <= GAP_LD;
              state <= ST_GAP;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) state <= ST_KEYCHK;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign status_n   = (state != ST_PULSE);
  assign dec_bypass = !enc_active;

endmodule

// File: rtl/bitsec_policy_ctrl.sv
module bitsec_policy_ctrl
  import sec_pol_pkg::*;
#(
  parameter int PULSE_W   = 4,
  parameter int RETRY_GAP = 6,
  parameter int FAIL_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vol_prog,
  input  logic              vol_erase,
  input  logic              vol_tamper_in,
  input  logic              nv_prog,
  input  logic              nv_tamper_in,
  input  logic              cfg_start,
  input  logic              cfg_jtag,
  input  logic              cfg_enc,
  input  logic              cfg_cmp,
  input  logic              key_vld,
  input  logic              key_ok,
  output logic              dec_bypass,
  output logic [1:0]        route,
  output logic              cfg_accept,
  output logic              cfg_reject,
  output logic              status_n,
  output logic [2:0]        mode_code,
  output logic [FAIL_W-1:0] fail_count
);

  sec_mode_e mode;
  logic      nv_locked;
  logic      start_taken;
  logic      key_fail;

  sec_key_store u_keys (
    .clk           (clk),
    .rst_n         (rst_n),
    .vol_prog      (vol_prog),
    .vol_erase     (vol_erase),
    .vol_tamper_in (vol_tamper_in),
    .nv_prog       (nv_prog),
    .nv_tamper_in  (nv_tamper_in),
    .mode          (mode),
    .nv_locked     (nv_locked)
  );

  sec_cfg_seq #(
    .PULSE_W   (PULSE_W),
    .RETRY_GAP (RETRY_GAP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .cfg_start   (cfg_start),
    .cfg_jtag    (cfg_jtag),
    .cfg_enc     (cfg_enc),
    .cfg_cmp     (cfg_cmp),
    .key_vld     (key_vld),
    .key_ok      (key_ok),
    .cfg_accept  (cfg_accept),
    .cfg_reject  (cfg_reject),
    .status_n    (status_n),
    .dec_bypass  (dec_bypass),
    .route       (route),
    .start_taken (start_taken),
    .key_fail    (key_fail)
  );

  sec_fail_tally #(
    .FAIL_W (FAIL_W)
  ) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_fail (key_fail),
    .count    (fail_count)
  );

  assign mode_code = mode;

endmodule

// File: rtl/sec_guard_chk.sv
module sec_guard_chk #(
  parameter int PULSE_W = 4,
  parameter int FAIL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_taken,
  input logic              key_fail,
  input logic              nv_locked,
  input logic              cfg_jtag,
  input logic              cfg_enc,
  input logic [2:0]        mode_code,
  input logic              cfg_accept,
  input logic              cfg_reject,
  input logic              status_n,
  input logic [FAIL_W-1:0] fail_count
);

  localparam int RUN_W = $clog2(PULSE_W + 2);
  localparam logic [FAIL_W-1:0] CNT_MAX = '1;

  logic [RUN_W-1:0] low_run;
  logic             tmp_mode;

  assign tmp_mode = (mode_code == 3'd2) || (mode_code == 3'd4);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (!status_n) low_run <= low_run + 1'b1;
    else                low_run <= '0;
  end

  // R4
  tamper_plain_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken && !cfg_jtag && !cfg_enc && tmp_mode |=> cfg_reject);

  // R5
  jtag_enc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken && cfg_jtag && cfg_enc |=> cfg_reject);

  // R5
  jtag_tamper_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken && cfg_jtag && tmp_mode |=> cfg_reject);

  // R6
  nokey_enc_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_taken && cfg_enc && (mode_code == 3'd0) |=> cfg_reject);

  // R7
  fail_tally_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_fail && (fail_count != CNT_MAX) |=> fail_count == FAIL_W'($past(fail_count) + 1'b1));

  // R7
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status_n |-> low_run < RUN_W'(PULSE_W));

  // R8
  low_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_n) |-> cfg_reject);

  // R8
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_accept && cfg_reject));

  // R9
  fuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_locked |=> nv_locked && $stable(mode_code));

endmodule

bind bitsec_policy_ctrl sec_guard_chk #(
  .PULSE_W (PULSE_W),
  .FAIL_W  (FAIL_W)
) u_guard_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_taken (start_taken),
  .key_fail    (key_fail),
  .nv_locked   (nv_locked),
  .cfg_jtag    (cfg_jtag),
  .cfg_enc     (cfg_enc),
  .mode_code   (mode_code),
  .cfg_accept  (cfg_accept),
  .cfg_reject  (cfg_reject),
  .status_n    (status_n),
  .fail_count  (fail_count)
);

// File: tb/test_bitsec_policy_ctrl.sv
`timescale 1ns/1ps
module test_bitsec_policy_ctrl;

  localparam int PW = 3;
  localparam int GP = 5;
  localparam int FW = 3;
  localparam int FMAX = (1 << FW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vol_prog = 0, vol_erase = 0, vol_tamper_in = 0;
  logic nv_prog = 0, nv_tamper_in = 0;
  logic cfg_start = 0, cfg_jtag = 0, cfg_enc = 0, cfg_cmp = 0;
  logic key_vld = 0, key_ok = 0;
  logic          dec_bypass;
  logic [1:0]    route;
  logic          cfg_accept, cfg_reject, status_n;
  logic [2:0]    mode_code;
  logic [FW-1:0] fail_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of key store
  bit m_vp, m_vt, m_np, m_nt;
  int m_fail;

  always #4 clk = ~clk;

  bitsec_policy_ctrl #(.PULSE_W(PW), .RETRY_GAP(GP), .FAIL_W(FW)) i_bitsec_policy_ctrl (
    .clk(clk), .rst_n(rst_n),
    .vol_prog(vol_prog), .vol_erase(vol_erase), .vol_tamper_in(vol_tamper_in),
    .nv_prog(nv_prog), .nv_tamper_in(nv_tamper_in),
    .cfg_start(cfg_start), .cfg_jtag(cfg_jtag), .cfg_enc(cfg_enc), .cfg_cmp(cfg_cmp),
    .key_vld(key_vld), .key_ok(key_ok),
    .dec_bypass(dec_bypass), .route(route), .cfg_accept(cfg_accept),
    .cfg_reject(cfg_reject), .status_n(status_n), .mode_code(mode_code),
    .fail_count(fail_count)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_mode();
    if (m_np) return m_nt ? 4 : 3;
    if (m_vp) return m_vt ? 2 : 1;
    return 0;
  endfunction

  // 0 refuse, 1 accept plain, 2 key check
  function automatic int exp_decide(bit jtag, bit enc);
    bit tam = m_np ? m_nt : (m_vp && m_vt);
    bit key = m_np || m_vp;
    if (jtag) return (!enc && !tam) ? 1 : 0;
    if (!enc) return tam ? 0 : 1;
    return key ? 2 : 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_vp = 0; m_vt = 0; m_np = 0; m_nt = 0; m_fail = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic vol_op(bit erase, bit prog, bit t);
    vol_erase = erase; vol_prog = prog; vol_tamper_in = t;
    @(negedge clk);
    vol_erase = 0; vol_prog = 0;
    if (erase) begin m_vp = 0; m_vt = 0; end
    else if (prog) begin m_vp = 1; m_vt = t; end
    chk("R10 battery key mode", mode_code, exp_mode());
  endtask

  task automatic nv_op(bit t);
    nv_prog = 1; nv_tamper_in = t;
    @(negedge clk);
    nv_prog = 0;
    if (!m_np) begin m_np = 1; m_nt = t; end
    chk("R9 fuse key mode", mode_code, exp_mode());
  endtask

  task automatic stream(bit jtag, bit enc, bit cmp, int nbad);
    int d = exp_decide(jtag, enc);
    cfg_start = 1; cfg_jtag = jtag; cfg_enc = enc; cfg_cmp = cmp;
    @(negedge clk);
    cfg_start = 0;
    if (d == 0) begin
      chk("R4/R5/R6 refusal pulse", cfg_reject, 1);
      chk("R8 no accept on refusal", cfg_accept, 0);
      chk("R8 status low", status_n, 0);
      chk("R8 bypass kept", dec_bypass, 1);
      for (int i = 1; i < PW; i++) begin
        @(negedge clk);
        chk("R8 status held low", status_n, 0);
      end
      @(negedge clk);
      chk("R8 status back high", status_n, 1);
      chk("R8 tally unchanged", fail_count, m_fail);
    end else if (d == 1) begin
      chk("R2/R3 plain accept", cfg_accept, 1);
      chk("R2/R3 bypass", dec_bypass, 1);
      chk("R11 plain route", route, {cmp, 1'b0});
    end else begin
      chk("R3 key check entered", {cfg_accept, cfg_reject, status_n, dec_bypass}, 4'b0010);
      for (int k = 0; k < nbad; k++) begin
        key_vld = 1; key_ok = 0;
        @(negedge clk);
        key_vld = 0;
        m_fail = (m_fail == FMAX) ? FMAX : m_fail + 1;
        chk("R7 fail reject", cfg_reject, 1);
        chk("R7 status low", status_n, 0);
        chk("R7 tally", fail_count, m_fail);
        for (int i = 1; i < PW; i++) begin
          @(negedge clk);
          chk("R7 status held low", status_n, 0);
        end
        @(negedge clk);
        chk("R7 gap high", status_n, 1);
        cfg_start = 1; cfg_jtag = 0; cfg_enc = 0;
        @(negedge clk);
        cfg_start = 0;
        chk("R12 start ignored in gap", {cfg_accept, cfg_reject}, 0);
        repeat (GP - 1) @(negedge clk);
      end
      key_vld = 1; key_ok = 1;
      @(negedge clk);
      key_vld = 0;
      chk("R3 key pass accept", cfg_accept, 1);
      chk("R3 decrypt in path", dec_bypass, 0);
      chk("R11 encrypted route", route, {cmp, 1'b1});
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    do_reset();
    // R13 reset state
    chk("R13 status", status_n, 1);
    chk("R13 mode", mode_code, 0);
    chk("R13 bypass", dec_bypass, 1);
    chk("R13 route", route, 0);
    chk("R13 tally", fail_count, 0);
    chk("R13 pulses", {cfg_accept, cfg_reject}, 0);

    // R2 / R6 no key
    stream(0, 0, 1, 0);
    stream(1, 0, 0, 0);
    stream(0, 1, 0, 0);
    stream(1, 1, 1, 0);

    // R1 / R3 / R7 battery key, no tamper
    vol_op(0, 1, 0);
    chk("R1 mode battery", mode_code, 1);
    stream(0, 0, 0, 0);
    stream(0, 1, 0, 2);
    stream(1, 1, 0, 0);
    stream(1, 0, 1, 0);

    // R4 / R5 / R11 battery key with tamper
    vol_op(0, 1, 1);
    chk("R1 mode battery tamper", mode_code, 2);
    stream(0, 0, 0, 0);
    stream(1, 0, 0, 0);
    stream(0, 1, 1, 0);

    // R10 erase wins over program
    vol_op(1, 1, 1);
    chk("R10 erase wins", mode_code, 0);

    // random mix, battery key only
    for (int n = 0; n < 60; n++) begin
      int op = $urandom % 6;
      if (op == 0)      vol_op(0, 1, 1'($urandom));
      else if (op == 1) vol_op(1, 1'($urandom), 1'($urandom));
      else stream(1'($urandom), 1'($urandom), 1'($urandom), $urandom % 3);
    end

    // R7 saturation
    vol_op(0, 1, 0);
    stream(0, 1, 0, FMAX + 2);
    chk("R7 tally saturated", fail_count, FMAX);

    // R9 fuse key and priority
    nv_op(0);
    chk("R1 mode fuse", mode_code, 3);
    nv_op(1);
    chk("R9 second fuse program ignored", mode_code, 3);
    vol_op(0, 1, 1);
    chk("R1 fuse priority", mode_code, 3);
    stream(0, 0, 0, 0);
    chk("R9 plain still accepted", dec_bypass, 1);

    // fuse key with tamper
    do_reset();
    nv_op(1);
    chk("R1 mode fuse tamper", mode_code, 4);
    vol_op(1, 0, 0);
    chk("R9 fuse unaffected by erase", mode_code, 4);

    for (int n = 0; n < 40; n++) begin
      int op = $urandom % 5;
      if (op == 0)      nv_op(1'($urandom));
      else if (op == 1) vol_op(1'($urandom), 1, 1'($urandom));
      else stream(1'($urandom), 1'($urandom), 1'($urandom), $urandom % 3);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule